// File: doc/BRIEF.md
# Pin Control Register Bank

This block is a small memory-mapped controller for a group of general-purpose pins. A host reaches it over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Two storage registers drive the pins: one holds the level each pin drives, and one holds the per-pin direction, where a one makes the pin an output. The pin output enables follow the direction bits, and the pin output values follow the level bits.

Each of the two storage registers has three write addresses. One replaces the whole value. One sets the bits written as one. One clears the bits written as one. Software can therefore change a single pin in one bus write, with no read-modify-write sequence. A read-only register returns the pin input levels after a two-flop synchroniser. Reset is asserted asynchronously and released in step with the clock.

Top module: `pin_ctrl_bank`

## Requirements
- R1: While reset is asserted and after it is released, the level register and the direction register hold zero, and pin_out and pin_oe are zero. All pins therefore start as inputs.
- R2: A write to offset 0x00 replaces the level register with write data bits 15:0. A read of offset 0x00 returns the value held there.
- R3: A write to offset 0x04 sets each level-register bit whose write-data bit is one. All other bits keep their values.
- R4: A write to offset 0x08 clears each level-register bit whose write-data bit is one. All other bits keep their values.
- R5: A write to offset 0x0C replaces the direction register. A read of offset 0x0C returns the value held there. pin_oe equals the direction register.
- R6: Offsets 0x10 and 0x14 set and clear direction-register bits in the same way that 0x04 and 0x08 act on the level register.
- R7: A read of offset 0x18 returns pin_in. A change on pin_in becomes visible after exactly two rising clock edges.
- R8: A read of any set or clear alias (0x04, 0x08, 0x10, 0x14) returns zero. A read of any unmapped offset (for example 0x1C, or a misaligned one such as 0x02) also returns zero.
- R9: A write to offset 0x18 or to an unmapped offset changes neither storage register. A write of all-zero data to a set or clear alias changes nothing.
- R10: Only bits 15:0 are implemented. Read data bits 31:16 are always zero, and write data bits 31:16 are ignored.
- R11: pin_out equals the level register, and it changes in the cycle after the write that alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 16 | Raw pin input levels, asynchronous |
| pin_out | output | 16 | Level driven on each pin |
| pin_oe | output | 16 | Output enable for each pin |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable around each rising edge and that a write lasts exactly one cycle. They also assume that pin_in settles between edges, so that the two-stage latency property compares defined values. The bench drives every bus input and pin_in on the falling edge, raises bus_we for one cycle only, and samples one time unit after the falling edge. As a result, every write is captured exactly once and every sample sees settled combinational read data.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // Byte offsets of the register windows
  localparam int unsigned OFF_LVL     = 32'h00;
  localparam int unsigned OFF_LVL_SET = 32'h04;
  localparam int unsigned OFF_LVL_CLR = 32'h08;
  localparam int unsigned OFF_DIR     = 32'h0C;
  localparam int unsigned OFF_DIR_SET = 32'h10;
  localparam int unsigned OFF_DIR_CLR = 32'h14;
  localparam int unsigned OFF_PINS    = 32'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LVL,
    SEL_LVL_SET,
    SEL_LVL_CLR,
    SEL_DIR,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_PINS
  } reg_sel_e;

  // Per-register update request: full load, bitwise set, bitwise clear
  typedef struct packed {
    logic load;
    logic set;
    logic clr;
  } bit_op_t;

endpackage

// File: rtl/pcb_rst_sync.sv
module pcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pcb_sync.sv
module pcb_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign chain_d[s] = d;
    end else begin : g_next
      assign chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d[s];
    end
  end

  assign q = chain_q[STAGES-1];

  // Two-edge latency check, armed only once two edges have passed since reset
  if (STAGES == 2) begin : g_chk2
    logic [1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            seen_q <= 2'd0;
      else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end

    a_r7_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q == 2'd2) |-> (q == $past(d, 2)));
  end

endmodule

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output bit_op_t           lvl_op,
  output bit_op_t           dir_op
);

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_LVL))     sel = SEL_LVL;
    else if (addr == ADDR_W'(OFF_LVL_SET)) sel = SEL_LVL_SET;
    else if (addr == ADDR_W'(OFF_LVL_CLR)) sel = SEL_LVL_CLR;
    else if (addr == ADDR_W'(OFF_DIR))     sel = SEL_DIR;
    else if (addr == ADDR_W'(OFF_DIR_SET)) sel = SEL_DIR_SET;
    else if (addr == ADDR_W'(OFF_DIR_CLR)) sel = SEL_DIR_CLR;
    else if (addr == ADDR_W'(OFF_PINS))    sel = SEL_PINS;
  end

  always_comb begin
    lvl_op = '0;
    dir_op = '0;
    if (we) begin
      unique case (sel)
        SEL_LVL:     lvl_op.load = 1'b1;
        SEL_LVL_SET: lvl_op.set  = 1'b1;
        SEL_LVL_CLR: lvl_op.clr  = 1'b1;
        SEL_DIR:     dir_op.load = 1'b1;
        SEL_DIR_SET: dir_op.set  = 1'b1;
        SEL_DIR_CLR: dir_op.clr  = 1'b1;
        default: ;
      endcase
    end
  end

  // R9: at most one storage update per bus write, none for read-only or unmapped
  always_comb begin
    a_r9_single_update: assert ($onehot0({lvl_op, dir_op}));
  end

endmodule

// File: rtl/pcb_bitreg.sv
module pcb_bitreg
  import pcb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bit_op_t      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd_en;

  assign upd_en = op.load | op.set | op.clr;

  always_comb begin
    q_nxt = q_r;
    if      (op.load) q_nxt = wdata;
    else if (op.set)  q_nxt = q_r | wdata;
    else if (op.clr)  q_nxt = q_r & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (upd_en) q_r <= q_nxt;
  end

  assign q = q_r;

  a_r2_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    op.load |=> (q == $past(wdata)));

  a_r3_set_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    op.set |=> (((q & $past(wdata)) == $past(wdata)) &&
                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

  a_r4_clear_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    op.clr |=> (((q & $past(wdata)) == '0) &&
                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

  a_r9_hold_without_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(op.load || op.set || op.clr) |=> $stable(q));

endmodule

// File: rtl/pcb_rdmux.sv
module pcb_rdmux
  import pcb_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  reg_sel_e          sel,
  input  logic [PINS-1:0]   lvl_q,
  input  logic [PINS-1:0]   dir_q,
  input  logic [PINS-1:0]   pins_q,
  output logic [DATA_W-1:0] rdata
);

  logic [PINS-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_LVL:  pick = lvl_q;
      SEL_DIR:  pick = dir_q;
      SEL_PINS: pick = pins_q;
      default:  pick = '0;
    endcase
  end

  assign rdata = DATA_W'(pick);

endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
  import pcb_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  localparam int unsigned SYNC_STAGES = 2;

  logic            rst_sync_n;
  reg_sel_e        sel;
  bit_op_t         lvl_op;
  bit_op_t         dir_op;
  logic [PINS-1:0] wbits;
  logic [PINS-1:0] lvl_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] pins_q;

  assign wbits = bus_wdata[PINS-1:0];

  pcb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcb_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .sel    (sel),
    .lvl_op (lvl_op),
    .dir_op (dir_op)
  );

  pcb_bitreg #(.W(PINS)) i_lvl_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op    (lvl_op),
    .wdata (wbits),
    .q     (lvl_q)
  );

  pcb_bitreg #(.W(PINS)) i_dir_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op    (dir_op),
    .wdata (wbits),
    .q     (dir_q)
  );

  pcb_sync #(.W(PINS), .STAGES(SYNC_STAGES)) i_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_in),
    .q     (pins_q)
  );

  pcb_rdmux #(.PINS(PINS), .DATA_W(DATA_W)) i_rdmux (
    .sel    (sel),
    .lvl_q  (lvl_q),
    .dir_q  (dir_q),
    .pins_q (pins_q),
    .rdata  (bus_rdata)
  );

  assign pin_out = lvl_q;
  assign pin_oe  = dir_q;

  a_r8_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_addr == ADDR_W'(OFF_LVL_SET)) || (bus_addr == ADDR_W'(OFF_LVL_CLR)) ||
     (bus_addr == ADDR_W'(OFF_DIR_SET)) || (bus_addr == ADDR_W'(OFF_DIR_CLR)))
    |-> (bus_rdata == '0));

  a_r1_reset_clears_pins: assert property (@(posedge clk)
    !rst_sync_n |-> ((pin_oe == '0) && (pin_out == '0)));

  a_r11_out_moves_only_on_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(lvl_op.load || lvl_op.set || lvl_op.clr) |=> $stable(pin_out));

endmodule

// File: tb/test_pin_ctrl_bank.sv
module test_pin_ctrl_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = 16'h0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pin_ctrl_bank i_pin_ctrl_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  typedef struct packed {
    logic [7:0]  waddr;
    logic        we;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp_rd;
    logic [15:0] exp_out;
    logic [15:0] exp_oe;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{8'h00, 1'b1, 32'hFFFF_A5C3, 8'h00, 32'h0000_A5C3, 16'hA5C3, 16'h0000}, // R2 R10
    '{8'h04, 1'b1, 32'h0000_0A1C, 8'h00, 32'h0000_AFDF, 16'hAFDF, 16'h0000}, // R3
    '{8'h08, 1'b1, 32'h0000_F00F, 8'h00, 32'h0000_0FD0, 16'h0FD0, 16'h0000}, // R4
    '{8'h0C, 1'b1, 32'h1234_00FF, 8'h0C, 32'h0000_00FF, 16'h0FD0, 16'h00FF}, // R5 R10
    '{8'h10, 1'b1, 32'h0000_8100, 8'h0C, 32'h0000_81FF, 16'h0FD0, 16'h81FF}, // R6 set
    '{8'h14, 1'b1, 32'h0000_0181, 8'h0C, 32'h0000_807E, 16'h0FD0, 16'h807E}, // R6 clear
    '{8'h18, 1'b1, 32'hFFFF_FFFF, 8'h00, 32'h0000_0FD0, 16'h0FD0, 16'h807E}, // R9
    '{8'h1C, 1'b1, 32'h0000_FFFF, 8'h0C, 32'h0000_807E, 16'h0FD0, 16'h807E}, // R9
    '{8'h04, 1'b0, 32'h0,         8'h04, 32'h0,         16'h0FD0, 16'h807E}, // R8
    '{8'h08, 1'b0, 32'h0,         8'h08, 32'h0,         16'h0FD0, 16'h807E}, // R8
    '{8'h10, 1'b0, 32'h0,         8'h10, 32'h0,         16'h0FD0, 16'h807E}, // R8
    '{8'h14, 1'b0, 32'h0,         8'h14, 32'h0,         16'h0FD0, 16'h807E}, // R8
    '{8'h1C, 1'b0, 32'h0,         8'h1C, 32'h0,         16'h0FD0, 16'h807E}, // R8
    '{8'h04, 1'b1, 32'h0,         8'h00, 32'h0000_0FD0, 16'h0FD0, 16'h807E}, // R9 zero set
    '{8'h08, 1'b1, 32'hFFFF_0000, 8'h00, 32'h0000_0FD0, 16'h0FD0, 16'h807E}, // R9 R10 clear
    '{8'h02, 1'b1, 32'h0000_FFFF, 8'h02, 32'h0,         16'h0FD0, 16'h807E}  // R8 R9 misaligned
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we   = 1'b0;
    bus_addr = a;
    #1;
    check(req, "rdata", bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: during and after reset
    repeat (2) @(negedge clk);
    #1;
    check("R1", "pin_oe in reset", {16'h0, pin_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "pin_out after reset", {16'h0, pin_out}, 32'h0);
    check("R1", "pin_oe after reset", {16'h0, pin_oe}, 32'h0);
    rd_check("R1", 8'h00, 32'h0);
    rd_check("R1", 8'h0C, 32'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bus_addr  = VEC[i].waddr;
      bus_we    = VEC[i].we;
      bus_wdata = VEC[i].wdata;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_addr  = VEC[i].raddr;
      #1;
      check("R2-R11 vector", "rdata", bus_rdata, VEC[i].exp_rd);
      check("R11 vector", "pin_out", {16'h0, pin_out}, {16'h0, VEC[i].exp_out});
      check("R5 vector", "pin_oe", {16'h0, pin_oe}, {16'h0, VEC[i].exp_oe});
    end

    // R7: two-edge synchroniser latency on the input register
    @(negedge clk);
    bus_addr = 8'h18;
    pin_in   = 16'h3C5A;
    @(negedge clk);
    #1;
    check("R7", "pins after one edge", bus_rdata, 32'h0);
    @(negedge clk);
    #1;
    check("R7", "pins after two edges", bus_rdata, 32'h0000_3C5A);
    pin_in = 16'hC3A5;
    repeat (2) @(negedge clk);
    #1;
    check("R7", "pins second pattern", bus_rdata, 32'h0000_C3A5);

    // R11: pin_out changes in the cycle after the write
    @(negedge clk);
    bus_addr  = 8'h04;
    bus_we    = 1'b1;
    bus_wdata = 32'h0000_0001;
    #1;
    check("R11", "pin_out before edge", {16'h0, pin_out}, 32'h0000_0FD0);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    check("R11", "pin_out after edge", {16'h0, pin_out}, 32'h0000_0FD1);

    // R1: asynchronous reset mid-run clears outputs at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "pin_oe async clear", {16'h0, pin_oe}, 32'h0);
    check("R1", "pin_out async clear", {16'h0, pin_out}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_check("R1", 8'h00, 32'h0);
    rd_check("R1", 8'h0C, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule